// File: doc/BRIEF.md
# Quad Power-Rail Enable Sequencer

This block is a synchronous controller for four rail-enable outputs, named A, B, C and D. When the monitored supply is reported compliant and the sequence request is active, it first runs a start delay. It then raises A, B, C and D in that order, with a programmable gap before each of B, C and D. When the request is withdrawn, it runs the start delay again. It then lowers the rails in reverse order, D first, and uses the same gaps in mirror order.

If compliance is lost, every enable returns to its reset level on one clock edge, whatever the controller was doing. The controller then waits for compliance before starting over from the start delay. All delays are given in clock cycles. The compliance flag and the request pin are asynchronous, and each passes through a two-flop synchronizer. Parameters select the polarity of the enables and the polarity of the request pin.

Top module: `rail_seq_ctrl`

## Requirements
- R1: `i_compliant` and `i_seq_req` pass through two synchronizer flops. A level applied before clock edge e is acted on by the controller's state at edge e+2, so it shows at the outputs at edge e+2 at the earliest.
- R2: Turn-on starts only while compliance and the request are both active. Rail A asserts `i_start_cyc`+1 cycles after the controller enters its start phase. For a pin change sampled at edge e, that is edge e+3+`i_start_cyc`.
- R3: Rails turn on one at a time, in the order A, B, C, D. The gap from A to B is `i_gap_ab`+1 cycles, from B to C is `i_gap_bc`+1 cycles, and from C to D is `i_gap_cd`+1 cycles. A gap value of zero gives one cycle.
- R4: Withdrawing the request after turn-on runs the start delay again and then drops D. C follows `i_gap_cd`+1 cycles later, B follows `i_gap_bc`+1 cycles after that, and A follows `i_gap_ab`+1 cycles after that.
- R5: Loss of compliance, in any phase, clears all four rails on the same edge. This edge is two edges after the synchronizer samples the loss. A stage expiry falling on that same edge is overridden.
- R6: If compliance is lost during the start delay, no rail changes and the start is abandoned. When compliance returns, the full start delay runs again.
- R7: If the request becomes active again during turn-off, the turn-off is abandoned. The start delay runs again, and turn-on resumes with the lowest rail that is off.
- R8: With `OUT_ACT_LOW`=0 an enabled rail drives 1 and the reset level is 0. With `OUT_ACT_LOW`=1 each output is the bitwise inverse.
- R9: With `SEQ_ACT_LOW`=0 a high `i_seq_req` requests turn-on. With `SEQ_ACT_LOW`=1 a low level does.
- R10: While `rst` is high, all outputs sit at their reset level, `o_busy` is 0 and all timers are cleared.
- R11: `o_busy` is 1 in the start, rising, stopping and falling phases. It is 0 when all rails are off and idle, and 0 when all rails are on and steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_compliant | input | 1 | Supply-in-window flag, asynchronous |
| i_seq_req | input | 1 | Sequence request, polarity set by `SEQ_ACT_LOW` |
| i_start_cyc | input | CNT_W | Start delay in cycles, applied before the first change in either direction |
| i_gap_ab | input | CNT_W | Gap between A and B |
| i_gap_bc | input | CNT_W | Gap between B and C |
| i_gap_cd | input | CNT_W | Gap between C and D |
| o_rail_en | output | 4 | Rail enables, bit 0 is A and bit 3 is D, polarity set by `OUT_ACT_LOW` |
| o_busy | output | 1 | A timed phase is in progress |

## Verification
Two pairs of functions can fall in the same cycle, and the bench provokes both. The first pair is a compliance drop and a stage expiry. The bench drops compliance so that the clear lands on the very edge where C would have turned on. The edge must show 0000 and never 0111. The second pair is a request re-assertion and a pending turn-off step. The bench re-asserts the request during the C-off gap. The scoreboard then expects no C-off event and only a later return to 1111. Each expected event carries its exact cycle, so an early, late or extra transition is reported as a mismatch.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  localparam int unsigned RAILS = 4;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_RISE  = 3'd2,
    PH_FULL  = 3'd3,
    PH_STOP  = 3'd4,
    PH_FALL  = 3'd5
  } phase_e;

  function automatic logic [RAILS-1:0] therm(input logic [$clog2(RAILS+1)-1:0] lvl);
    logic [RAILS-1:0] t;
    for (int i = 0; i < RAILS; i++) t[i] = (i < int'(lvl));
    return t;
  endfunction
endpackage

// File: rtl/rail_sync.sv
module rail_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rail_gap_sel.sv
module rail_gap_sel #(
  parameter int CNT_W = 16,
  parameter int NGAP  = 3,
  parameter int LVL_W = 3
) (
  input  logic [NGAP-1:0][CNT_W-1:0] gaps,
  input  logic [LVL_W-1:0]           lvl,
  output logic [CNT_W-1:0]           gap
);
  always_comb begin
    gap = '0;
    for (int i = 0; i < NGAP; i++)
      if (lvl == LVL_W'(i + 1)) gap = gaps[i];
  end
endmodule

// File: rtl/rail_dly_timer.sv
module rail_dly_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] target,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = run && (cnt == target);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt <= '0;
    else if (cnt == target) cnt <= '0;
    else                    cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit OUT_ACT_LOW = 1'b0,
  parameter bit SEQ_ACT_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_compliant,
  input  logic             i_seq_req,
  input  logic [CNT_W-1:0] i_start_cyc,
  input  logic [CNT_W-1:0] i_gap_ab,
  input  logic [CNT_W-1:0] i_gap_bc,
  input  logic [CNT_W-1:0] i_gap_cd,
  output logic [3:0]       o_rail_en,
  output logic             o_busy
);
  localparam int LVL_W = $clog2(RAILS + 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(RAILS);

  logic comp_s, seq_raw, seq_on;
  rail_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({i_compliant, i_seq_req}),
    .q({comp_s, seq_raw})
  );
  assign seq_on = seq_raw ^ SEQ_ACT_LOW;

  phase_e           ph_q, ph_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [RAILS-1:0] rails_q;

  logic [RAILS-2:0][CNT_W-1:0] gaps;
  logic [CNT_W-1:0]            gap, target;
  logic                        run, done, clr;

  assign gaps = {i_gap_cd, i_gap_bc, i_gap_ab};

  rail_gap_sel #(.CNT_W(CNT_W), .NGAP(RAILS-1), .LVL_W(LVL_W)) u_gap (
    .gaps(gaps), .lvl(lvl_q), .gap(gap)
  );

  assign run    = (ph_q == PH_START) || (ph_q == PH_RISE) ||
                  (ph_q == PH_STOP)  || (ph_q == PH_FALL);
  assign target = ((ph_q == PH_START) || (ph_q == PH_STOP)) ? i_start_cyc : gap;
  assign clr    = (ph_d != ph_q);

  rail_dly_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .clr(clr), .run(run), .target(target), .done(done)
  );

  // next-phase logic; compliance loss outranks every other event
  always_comb begin
    ph_d  = ph_q;
    lvl_d = lvl_q;
    if (!comp_s) begin
      ph_d  = PH_IDLE;
      lvl_d = '0;
    end else begin
      unique case (ph_q)
        PH_IDLE:  if (seq_on) ph_d = PH_START;
        PH_START, PH_RISE: begin
          if (!seq_on) begin
            ph_d = (lvl_q == '0) ? PH_IDLE : PH_STOP;
          end else if (done) begin
            lvl_d = lvl_q + LVL_W'(1);
            ph_d  = (lvl_q + LVL_W'(1) == LVL_FULL) ? PH_FULL : PH_RISE;
          end
        end
        PH_FULL:  if (!seq_on) ph_d = PH_STOP;
        PH_STOP, PH_FALL: begin
          if (seq_on) begin
            ph_d = PH_START;
          end else if (done) begin
            lvl_d = lvl_q - LVL_W'(1);
            ph_d  = (lvl_q == LVL_W'(1)) ? PH_IDLE : PH_FALL;
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          lvl_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      lvl_q     <= '0;
      rails_q   <= '0;
      o_rail_en <= {RAILS{OUT_ACT_LOW}};
      o_busy    <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      lvl_q     <= lvl_d;
      rails_q   <= therm(lvl_d);
      o_rail_en <= therm(lvl_d) ^ {RAILS{OUT_ACT_LOW}};
      o_busy    <= (ph_d == PH_START) || (ph_d == PH_RISE) ||
                   (ph_d == PH_STOP)  || (ph_d == PH_FALL);
    end
  end
endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       comp_s,
  input logic       seq_on,
  input logic [3:0] rails
);
  // R5
  comp_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !comp_s |=> (rails == 4'd0));

  // R3
  thermo_shape_chk: assert property (@(posedge clk) disable iff (rst)
    ((rails & (rails + 4'd1)) == 4'd0));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rails != 4'd0) |-> ($countones(rails ^ $past(rails)) <= 1));

  // R2
  rise_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rails[0]) |-> ($past(comp_s) && $past(seq_on)));

  // R4
  orderly_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rails[0]) && $past(comp_s)) |-> !$past(seq_on));
endmodule

bind rail_seq_ctrl rail_seq_chk u_chk (
  .clk(clk), .rst(rst), .comp_s(comp_s), .seq_on(seq_on), .rails(rails_q)
);

// File: tb/rail_seq_ctrl_tb.sv
`timescale 1ns/1ps
module rail_seq_ctrl_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic comp = 1'b0;
  logic seq = 1'b0;
  logic [CNT_W-1:0] start_cyc = 16'd5;
  logic [CNT_W-1:0] gap_ab = 16'd0, gap_bc = 16'd3, gap_cd = 16'd7;
  logic [3:0] rail, rail_inv;
  logic busy, busy_inv;

  always #4 clk = ~clk;

  rail_seq_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .i_compliant(comp), .i_seq_req(seq),
    .i_start_cyc(start_cyc), .i_gap_ab(gap_ab), .i_gap_bc(gap_bc), .i_gap_cd(gap_cd),
    .o_rail_en(rail), .o_busy(busy)
  );

  rail_seq_ctrl #(.CNT_W(CNT_W), .OUT_ACT_LOW(1'b1), .SEQ_ACT_LOW(1'b1)) u_dut_inv (
    .clk(clk), .rst(rst), .i_compliant(comp), .i_seq_req(~seq),
    .i_start_cyc(start_cyc), .i_gap_ab(gap_ab), .i_gap_bc(gap_bc), .i_gap_cd(gap_cd),
    .o_rail_en(rail_inv), .o_busy(busy_inv)
  );

  typedef struct {
    int         cyc;
    logic [3:0] val;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] prev = 4'd0;

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_ev(input int c, input logic [3:0] v, input string tag);
    exp_t e;
    e.cyc = c; e.val = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic finish_run();
    chk(sb_q.size() == 0, "R3 pending events", sb_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // monitor: each output transition must match the head of the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (rail !== prev) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R3 unexpected transition", int'(rail), int'(prev));
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(rail === e.val, {e.tag, " value"}, int'(rail), int'(e.val));
          chk(cyc == e.cyc, {e.tag, " cycle"}, cyc, e.cyc);
        end
      end
      // R8 R9: inverted-polarity twin must mirror the outputs
      chk(rail_inv === ~rail, "R8 R9 polarity twin", int'(rail_inv), int'(~rail));
    end
    prev = rail;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n, m, p;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(rail == 4'h0, "R10 rail reset", int'(rail), 0);
    chk(rail_inv == 4'hF, "R10 R8 inverted reset", int'(rail_inv), 15);
    chk(busy == 1'b0, "R10 busy reset", int'(busy), 0);
    rst = 1'b0;

    // R2 R3 R1: full turn-on, start delay 5, gaps 0/3/7
    @(negedge clk);
    n = cyc; seq = 1'b1; comp = 1'b1;
    expect_ev(n + 9,  4'b0001, "R2 A on");
    expect_ev(n + 10, 4'b0011, "R3 B on zero gap");
    expect_ev(n + 14, 4'b0111, "R3 C on");
    expect_ev(n + 22, 4'b1111, "R3 D on");
    wait_until(n + 2);
    chk(busy == 1'b0, "R1 busy before sync", int'(busy), 0);
    wait_until(n + 5);
    chk(busy == 1'b1, "R11 busy in start", int'(busy), 1);
    wait_until(n + 25);
    chk(busy == 1'b0, "R11 busy when full", int'(busy), 0);

    // R4 turn-off
    n = cyc; seq = 1'b0;
    expect_ev(n + 9,  4'b0111, "R4 D off");
    expect_ev(n + 17, 4'b0011, "R4 C off");
    expect_ev(n + 21, 4'b0001, "R4 B off");
    expect_ev(n + 22, 4'b0000, "R4 A off");
    wait_until(n + 40);
    chk(rail == 4'h0, "R2 no start without request", int'(rail), 0);

    // R6 compliance lost during start delay
    n = cyc; seq = 1'b1;
    wait_until(n + 5);
    comp = 1'b0;
    wait_until(n + 14);
    chk(rail == 4'h0, "R6 start abandoned", int'(rail), 0);
    chk(busy == 1'b0, "R6 R11 idle after abandon", int'(busy), 0);

    // R6 full restart, then R5 drop on the same edge C was due
    m = cyc; comp = 1'b1;
    expect_ev(m + 9,  4'b0001, "R6 A on after full delay");
    expect_ev(m + 10, 4'b0011, "R3 B on");
    expect_ev(m + 14, 4'b0000, "R5 drop overrides C");
    wait_until(m + 11);
    comp = 1'b0;
    wait_until(m + 20);

    // R7 re-request during turn-off
    m = cyc; comp = 1'b1;
    expect_ev(m + 9,  4'b0001, "R2 A on");
    expect_ev(m + 10, 4'b0011, "R3 B on");
    expect_ev(m + 14, 4'b0111, "R3 C on");
    expect_ev(m + 22, 4'b1111, "R3 D on");
    wait_until(m + 24);
    n = cyc; seq = 1'b0;
    expect_ev(n + 9, 4'b0111, "R4 D off");
    wait_until(n + 10);
    p = cyc; seq = 1'b1;
    expect_ev(p + 9, 4'b1111, "R7 D back on");
    wait_until(p + 20);

    // R5 compliance loss when fully on
    n = cyc; comp = 1'b0;
    expect_ev(n + 3, 4'b0000, "R5 R1 all off at once");
    wait_until(n + 8);

    // R3 zero start delay with new gaps
    start_cyc = 16'd0; gap_ab = 16'd2; gap_bc = 16'd0; gap_cd = 16'd1;
    @(negedge clk);
    n = cyc; comp = 1'b1;
    expect_ev(n + 4, 4'b0001, "R2 A on zero start");
    expect_ev(n + 7, 4'b0011, "R3 B on");
    expect_ev(n + 8, 4'b0111, "R3 C on zero gap");
    expect_ev(n + 10, 4'b1111, "R3 D on");
    wait_until(n + 15);
    chk(rail == 4'hF, "R3 all on", int'(rail), 15);
    finish_run();
  end
endmodule